// File: doc/BRIEF.md
# Capture/Compare Channel with PWM Modes

This block is one channel of a programmable counter array together with the 16-bit timebase it shares with its neighbours. The timebase counts from zero up to a programmable limit while its run bit is set. In center-aligned mode it counts up to the limit and then back down to zero. The channel compares the count against an 18-bit active compare value and drives a single output pin. Depending on its operating mode, it works as edge-aligned PWM, center-aligned PWM, a square-wave generator with a moving match point, n-bit edge-aligned PWM, or a timer that captures the count on edges of an external input.

Software reaches the block through a plain synchronous write port with a 3-bit address and an 18-bit data word. A new compare value is written into an update register and stays pending. It is moved into the active compare register at the next limit event, so a running PWM period is never cut short. While the counter is stopped, it is moved on the next cycle. Three sticky flags record compare/capture events, intermediate overflows and limit events. Each flag is cleared by writing 1 to it, and each has its own enable into a shared interrupt output.

The timebase is a three-state machine. In TB_IDLE the counter is stopped. In TB_UP it counts upward, and in TB_DOWN it counts downward. The transitions are:
- TB_IDLE goes to TB_UP when the run bit is set.
- TB_UP goes to TB_DOWN when center mode reaches a non-zero limit.
- TB_DOWN goes to TB_UP at zero.
- Either counting state goes to TB_IDLE when run clears.
- A count load forces TB_UP when running and TB_IDLE when stopped.

Top module: `cc_channel`

## Requirements
- R1: After reset the output, count, active compare value, pending bit, all three flags and the interrupt are 0.
- R2: The count holds while the run bit (CFG bit 14) is 0, unless it is loaded by a write to address 3, which takes effect on the following cycle.
- R3: While running and counting up, a count equal to the limit (address 2) or equal to 0xFFFF is a limit event. It sets the limit flag (flag bit 2), and in non-center modes the count returns to 0 next.
- R4: In edge-aligned PWM (mode code 0, CFG bits 8:6), both a compare match (count equals compare bits 15:0) and a limit event apply the output action.
- R5: The output action code (CFG bits 1:0) is applied on the next clock edge: 0 inverts the output, 1 drives it high, 2 drives it low, 3 keeps it.
- R6: In center-aligned mode (code 1), the count rises to the limit and then falls to 0. A match while rising drives the output high, and a match while falling drives it low.
- R7: In square-wave mode (code 2), the match point starts at the compare value. After each match it advances by compare bits 15:0, and the action is applied.
- R8: In n-bit mode (code 4), n is CFG bits 5:2 plus one. A match compares only the low n bits. When the low n bits are all ones, that is an intermediate event: it applies the action and sets the intermediate flag (flag bit 1).
- R9: In timer mode (code 3), the input passes through two synchronizing flops. A rising edge (enable CFG bit 9) or a falling edge (enable CFG bit 10) copies the count into the compare register. An edge whose enable is clear is ignored.
- R10: Writing address 1 sets the pending bit. The value moves into the compare register at the next limit event, or on the next cycle if the counter is stopped, and pending clears on that edge.
- R11: A match (modes 0 to 4, only while running) or a capture sets the compare flag (flag bit 0). In timer mode, matches and captures also apply the action.
- R12: Writing 1 to a bit of address 4 clears that flag unless the flag's event occurs in the same cycle, in which case the flag stays set.
- R13: The interrupt is high when any flag is set together with its enable: compare CFG bit 11, intermediate bit 12, limit bit 13.
- R14: Writing address 5 sets the output to data bit 0. This write takes priority over any event in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 CFG, 1 update, 2 limit, 3 count load, 4 flag clear, 5 output level) |
| wr_data | input | 18 | Register write data |
| cap_in | input | 1 | Asynchronous capture input |
| pwm_out | output | 1 | Channel output level |
| cmp_value | output | 18 | Active compare register |
| upd_pending | output | 1 | Compare update waiting for transfer |
| count | output | 16 | Shared timebase count |
| cc_flag | output | 1 | Compare/capture flag |
| iovf_flag | output | 1 | Intermediate overflow flag |
| lim_flag | output | 1 | Limit/overflow flag |
| irq | output | 1 | Combined enabled interrupt |

## Verification
The hardest situation to reach from the ports is a flag-clear write that lands in the exact cycle in which the same flag is set again. The stimulus sets the limit to 0 and runs the counter, so that a limit event occurs on every cycle, and then issues the clear. A second hard case is the falling-slope match in center mode, which occurs only after the counter has turned at the limit. The vector table stops the counter exactly one step before and one step after that match, and the bench compares the output level and the count at both points.

// File: rtl/cc_pkg.sv
package cc_pkg;
    localparam int CNT_W  = 16;
    localparam int CMP_W  = 18;
    localparam int NSEL_W = 4;
    localparam int ADDR_W = 3;
    localparam int NFLAG  = 3;

    localparam int F_CC   = 0;
    localparam int F_IOVF = 1;
    localparam int F_LIM  = 2;

    localparam logic [ADDR_W-1:0] A_CFG = 3'd0;
    localparam logic [ADDR_W-1:0] A_UPD = 3'd1;
    localparam logic [ADDR_W-1:0] A_LIM = 3'd2;
    localparam logic [ADDR_W-1:0] A_CNT = 3'd3;
    localparam logic [ADDR_W-1:0] A_CLR = 3'd4;
    localparam logic [ADDR_W-1:0] A_OUT = 3'd5;

    typedef enum logic [2:0] {
        MD_EDGE   = 3'd0,
        MD_CENTER = 3'd1,
        MD_SQUARE = 3'd2,
        MD_TIMER  = 3'd3,
        MD_NBIT   = 3'd4
    } ch_mode_e;

    typedef enum logic [1:0] {
        ACT_TOGGLE = 2'd0,
        ACT_SET    = 2'd1,
        ACT_CLEAR  = 2'd2,
        ACT_HOLD   = 2'd3
    } out_act_e;

    typedef enum logic [1:0] {
        TB_IDLE,
        TB_UP,
        TB_DOWN
    } tb_state_e;

    typedef struct packed {
        logic              run;
        logic              lim_ie;
        logic              iovf_ie;
        logic              cc_ie;
        logic              fall_en;
        logic              rise_en;
        logic [2:0]        mode;
        logic [NSEL_W-1:0] nsel;
        logic [1:0]        act;
    } cfg_t;
endpackage

// File: rtl/cc_regs.sv
module cc_regs
    import cc_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int VW = CMP_W,
    parameter int AW = ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [VW-1:0]     wr_data,
    input  logic [NFLAG-1:0]  flag_set,
    output cfg_t              cfg,
    output logic [CW-1:0]     limit,
    output logic [VW-1:0]     upd_val,
    output logic              upd_wr,
    output logic              cnt_wr,
    output logic [CW-1:0]     cnt_val,
    output logic              out_wr,
    output logic              out_val,
    output logic [NFLAG-1:0]  flag_q
);
    localparam int CFG_W = $bits(cfg_t);

    logic clr_wr;

    assign upd_wr  = wr_en && (wr_addr == A_UPD);
    assign cnt_wr  = wr_en && (wr_addr == A_CNT);
    assign out_wr  = wr_en && (wr_addr == A_OUT);
    assign clr_wr  = wr_en && (wr_addr == A_CLR);
    assign cnt_val = wr_data[CW-1:0];
    assign out_val = wr_data[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg     <= '0;
            limit   <= '0;
            upd_val <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_CFG) cfg     <= cfg_t'(wr_data[CFG_W-1:0]);
            if (wr_addr == A_LIM) limit   <= wr_data[CW-1:0];
            if (wr_addr == A_UPD) upd_val <= wr_data;
        end
    end

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                     flag_q[i] <= 1'b0;
            else if (flag_set[i])           flag_q[i] <= 1'b1;
            else if (clr_wr && wr_data[i])  flag_q[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/cc_timebase.sv
module cc_timebase
    import cc_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          center,
    input  logic [CW-1:0] limit,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic [CW-1:0] count,
    output logic          down,
    output logic          lim_evt
);
    tb_state_e state, nxt;
    logic at_top, at_wrap, turn;

    assign at_top  = (count == limit);
    assign at_wrap = &count;
    assign turn    = center && at_top && (limit != '0);
    assign down    = (state == TB_DOWN);
    assign lim_evt = run && !down && (at_top || at_wrap);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TB_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            TB_IDLE, TB_UP: begin
                if (!run)      nxt = TB_IDLE;
                else if (turn) nxt = TB_DOWN;
                else           nxt = TB_UP;
            end
            TB_DOWN: begin
                if (!run)               nxt = TB_IDLE;
                else if (count == '0)   nxt = TB_UP;
            end
            default: nxt = TB_IDLE;
        endcase
        if (load) nxt = run ? TB_UP : TB_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (run) begin
            if (down) begin
                if (count == '0) count <= (limit == '0) ? '0 : CW'(1);
                else             count <= count - CW'(1);
            end else if (turn) begin
                count <= count - CW'(1);
            end else if (at_top) begin
                count <= '0;
            end else begin
                count <= count + CW'(1);
            end
        end
    end
endmodule

// File: rtl/cc_chan.sv
module cc_chan
    import cc_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int VW = CMP_W,
    parameter int NW = NSEL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  cfg_t          cfg,
    input  logic [CW-1:0] count,
    input  logic          down,
    input  logic          lim_evt,
    input  logic [VW-1:0] upd_val,
    input  logic          upd_wr,
    input  logic          out_wr,
    input  logic          out_val,
    input  logic          cap_in,
    output logic          out_q,
    output logic [VW-1:0] cmp_q,
    output logic          pending_q,
    output logic          cc_evt,
    output logic          iovf_evt
);
    localparam int PAD_W = VW - CW;

    logic [2:0]    sync;
    logic          rise, fall, cap, match, inter, act_evt, xfer;
    logic [NW:0]   nbits;
    logic [CW-1:0] mask, cmp_lo, next_pt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync <= '0;
        else        sync <= {sync[1:0], cap_in};
    end
    assign rise = sync[1] & ~sync[2];
    assign fall = ~sync[1] & sync[2];

    assign nbits  = {1'b0, cfg.nsel} + (NW+1)'(1);
    assign mask   = ~({CW{1'b1}} << nbits);
    assign cmp_lo = cmp_q[CW-1:0];

    always_comb begin
        match   = 1'b0;
        inter   = 1'b0;
        cap     = 1'b0;
        act_evt = 1'b0;
        unique case (cfg.mode)
            MD_EDGE: begin
                match   = cfg.run && (count == cmp_lo);
                act_evt = match || lim_evt;
            end
            MD_CENTER: begin
                match   = cfg.run && (count == cmp_lo);
            end
            MD_SQUARE: begin
                match   = cfg.run && (count == next_pt);
                act_evt = match;
            end
            MD_TIMER: begin
                match   = cfg.run && (count == cmp_lo);
                cap     = (rise && cfg.rise_en) || (fall && cfg.fall_en);
                act_evt = match || cap;
            end
            MD_NBIT: begin
                match   = cfg.run && ((count & mask) == (cmp_lo & mask));
                inter   = cfg.run && ((count & mask) == mask);
                act_evt = match || inter;
            end
            default: ;
        endcase
    end

    assign cc_evt   = match || cap;
    assign iovf_evt = inter;
    assign xfer     = pending_q && (lim_evt || !cfg.run);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= 1'b0;
        end else if (out_wr) begin
            out_q <= out_val;
        end else if (cfg.mode == MD_CENTER) begin
            if (match) out_q <= !down;
        end else if (act_evt) begin
            unique case (out_act_e'(cfg.act))
                ACT_TOGGLE: out_q <= ~out_q;
                ACT_SET:    out_q <= 1'b1;
                ACT_CLEAR:  out_q <= 1'b0;
                ACT_HOLD:   out_q <= out_q;
                default:    out_q <= out_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_q     <= '0;
            pending_q <= 1'b0;
            next_pt   <= '0;
        end else begin
            if (cap)       cmp_q <= {{PAD_W{1'b0}}, count};
            else if (xfer) cmp_q <= upd_val;
            if (upd_wr)    pending_q <= 1'b1;
            else if (xfer) pending_q <= 1'b0;
            if (!(cfg.run && cfg.mode == MD_SQUARE)) next_pt <= cmp_lo;
            else if (match)                          next_pt <= next_pt + cmp_lo;
        end
    end
endmodule

// File: rtl/cc_channel.sv
module cc_channel
    import cc_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int VW = CMP_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [VW-1:0] wr_data,
    input  logic          cap_in,
    output logic          pwm_out,
    output logic [VW-1:0] cmp_value,
    output logic          upd_pending,
    output logic [CW-1:0] count,
    output logic          cc_flag,
    output logic          iovf_flag,
    output logic          lim_flag,
    output logic          irq
);
    cfg_t             cfg;
    logic [CW-1:0]    limit, cnt_val;
    logic [VW-1:0]    upd_val;
    logic             upd_wr, cnt_wr, out_wr, out_val;
    logic             down, lim_evt, cc_evt, iovf_evt;
    logic [NFLAG-1:0] flag_set, flag_q, flag_en;

    assign flag_set = {lim_evt, iovf_evt, cc_evt};
    assign flag_en  = {cfg.lim_ie, cfg.iovf_ie, cfg.cc_ie};

    cc_regs #(.CW(CW), .VW(VW), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .flag_set(flag_set), .cfg(cfg), .limit(limit),
        .upd_val(upd_val), .upd_wr(upd_wr), .cnt_wr(cnt_wr),
        .cnt_val(cnt_val), .out_wr(out_wr), .out_val(out_val),
        .flag_q(flag_q)
    );

    cc_timebase #(.CW(CW)) u_tb (
        .clk(clk), .rst_n(rst_n), .run(cfg.run),
        .center(cfg.mode == MD_CENTER), .limit(limit), .load(cnt_wr),
        .load_val(cnt_val), .count(count), .down(down), .lim_evt(lim_evt)
    );

    cc_chan #(.CW(CW), .VW(VW), .NW(NSEL_W)) u_chan (
        .clk(clk), .rst_n(rst_n), .cfg(cfg), .count(count), .down(down),
        .lim_evt(lim_evt), .upd_val(upd_val), .upd_wr(upd_wr),
        .out_wr(out_wr), .out_val(out_val), .cap_in(cap_in),
        .out_q(pwm_out), .cmp_q(cmp_value), .pending_q(upd_pending),
        .cc_evt(cc_evt), .iovf_evt(iovf_evt)
    );

    assign cc_flag   = flag_q[F_CC];
    assign iovf_flag = flag_q[F_IOVF];
    assign lim_flag  = flag_q[F_LIM];
    assign irq       = |(flag_q & flag_en);
endmodule

// File: rtl/cc_channel_chk.sv
module cc_channel_chk #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          run,
    input logic          lim_evt,
    input logic          cc_evt,
    input logic          iovf_evt,
    input logic          pending,
    input logic          cnt_wr,
    input logic [CW-1:0] count,
    input logic          cc_flag,
    input logic          iovf_flag,
    input logic          lim_flag,
    input logic          out,
    input logic          out_wr,
    input logic [1:0]    act,
    input logic [2:0]    mode
);
    // R10
    pend_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pending) |-> $past(lim_evt || !run));

    // R3
    lim_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lim_evt |=> lim_flag);

    // R11
    cc_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cc_evt |=> cc_flag);

    // R8
    iovf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iovf_evt |=> iovf_flag);

    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_wr) |=> $stable(count));

    // R5
    out_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act == 2'd3 && mode != 3'd1 && !out_wr) |=> $stable(out));
endmodule

bind cc_channel cc_channel_chk #(.CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .run(cfg.run), .lim_evt(lim_evt),
    .cc_evt(cc_evt), .iovf_evt(iovf_evt), .pending(upd_pending),
    .cnt_wr(cnt_wr), .count(count), .cc_flag(cc_flag),
    .iovf_flag(iovf_flag), .lim_flag(lim_flag), .out(pwm_out),
    .out_wr(out_wr), .act(cfg.act), .mode(cfg.mode)
);

// File: tb/sim_cc_channel.sv
module sim_cc_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [17:0] wr_data = '0;
    logic        cap_in = 1'b0;
    logic        pwm_out, upd_pending, cc_flag, iovf_flag, lim_flag, irq;
    logic [17:0] cmp_value;
    logic [15:0] count;
    int checks = 0;
    int bad = 0;

    always #10 clk = ~clk;

    cc_channel u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cap_in(cap_in), .pwm_out(pwm_out),
        .cmp_value(cmp_value), .upd_pending(upd_pending), .count(count),
        .cc_flag(cc_flag), .iovf_flag(iovf_flag), .lim_flag(lim_flag),
        .irq(irq)
    );

    typedef struct packed {
        logic [2:0]  mode;
        logic [1:0]  act;
        logic [3:0]  nsel;
        logic        init;
        logic [15:0] lim;
        logic [17:0] cv;
        logic [7:0]  steps;
        logic        eo;
        logic [15:0] ec;
        logic        ecc;
        logic        eiv;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 2'd0, 4'd0, 1'b0, 16'd9,  18'd4, 8'd3,  1'b0, 16'd3,  1'b0, 1'b0}, // R4 before match
        '{3'd0, 2'd0, 4'd0, 1'b0, 16'd9,  18'd4, 8'd7,  1'b1, 16'd7,  1'b1, 1'b0}, // R4 R5 toggle at match
        '{3'd0, 2'd0, 4'd0, 1'b0, 16'd9,  18'd4, 8'd12, 1'b0, 16'd2,  1'b1, 1'b0}, // R4 R3 wrap toggles back
        '{3'd0, 2'd1, 4'd0, 1'b0, 16'd9,  18'd4, 8'd5,  1'b1, 16'd5,  1'b1, 1'b0}, // R5 set
        '{3'd0, 2'd3, 4'd0, 1'b0, 16'd9,  18'd4, 8'd7,  1'b0, 16'd7,  1'b1, 1'b0}, // R5 none, R11 flag
        '{3'd0, 2'd2, 4'd0, 1'b1, 16'd9,  18'd2, 8'd4,  1'b0, 16'd4,  1'b1, 1'b0}, // R5 clear
        '{3'd1, 2'd0, 4'd0, 1'b0, 16'd5,  18'd3, 8'd7,  1'b1, 16'd3,  1'b1, 1'b0}, // R6 rising match
        '{3'd1, 2'd0, 4'd0, 1'b0, 16'd5,  18'd3, 8'd8,  1'b0, 16'd2,  1'b1, 1'b0}, // R6 falling match
        '{3'd4, 2'd0, 4'd1, 1'b0, 16'd15, 18'd1, 8'd3,  1'b1, 16'd3,  1'b1, 1'b0}, // R8 low-bit match
        '{3'd4, 2'd0, 4'd1, 1'b0, 16'd15, 18'd1, 8'd4,  1'b0, 16'd4,  1'b1, 1'b1}, // R8 intermediate
        '{3'd2, 2'd0, 4'd0, 1'b0, 16'd99, 18'd3, 8'd10, 1'b1, 16'd10, 1'b1, 1'b0}, // R7 three matches
        '{3'd3, 2'd0, 4'd0, 1'b0, 16'd99, 18'd4, 8'd5,  1'b1, 16'd5,  1'b1, 1'b0}  // R11 timer match
    };

    function automatic logic [17:0] mk_cfg(input logic [2:0] mode, input logic [1:0] act,
                                           input logic [3:0] nsel, input logic rise,
                                           input logic fall, input logic ccie,
                                           input logic ivie, input logic limie,
                                           input logic run);
        return {3'b0, run, limie, ivie, ccie, fall, rise, mode, nsel, act};
    endfunction

    function automatic string req_of(input logic [2:0] mode);
        case (mode)
            3'd0: return "R4";
            3'd1: return "R6";
            3'd2: return "R7";
            3'd4: return "R8";
            default: return "R11";
        endcase
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [17:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(20 * 200000);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        chk("R1", "out", 32'(pwm_out), 0);
        chk("R1", "count", 32'(count), 0);
        chk("R1", "cmp", 32'(cmp_value), 0);
        chk("R1", "pending", 32'(upd_pending), 0);
        chk("R1", "flags", 32'({lim_flag, iovf_flag, cc_flag}), 0);
        chk("R1", "irq", 32'(irq), 0);

        for (int i = 0; i < NV; i++) begin
            vec_t v = VECS[i];
            wr(3'd0, mk_cfg(v.mode, v.act, v.nsel, 0, 0, 0, 0, 0, 0));
            wr(3'd5, {17'd0, v.init});
            wr(3'd3, 18'd0);
            wr(3'd2, {2'b0, v.lim});
            wr(3'd1, v.cv);
            idle(2);
            wr(3'd4, 18'd7);
            wr(3'd0, mk_cfg(v.mode, v.act, v.nsel, 0, 0, 0, 0, 0, 1));
            idle(int'(v.steps) - 2);
            wr(3'd0, mk_cfg(v.mode, v.act, v.nsel, 0, 0, 0, 0, 0, 0));
            chk(req_of(v.mode), $sformatf("row%0d out", i), 32'(pwm_out), 32'(v.eo));
            chk(req_of(v.mode), $sformatf("row%0d count", i), 32'(count), 32'(v.ec));
            chk("R11", $sformatf("row%0d cc", i), 32'(cc_flag), 32'(v.ecc));
            chk("R8", $sformatf("row%0d iovf", i), 32'(iovf_flag), 32'(v.eiv));
        end

        // R10 stopped: transfer on next cycle
        wr(3'd1, 18'h2ABCD);
        chk("R10", "pending set", 32'(upd_pending), 1);
        chk("R10", "cmp not yet", 32'(cmp_value), 4);
        idle(1);
        chk("R10", "cmp moved", 32'(cmp_value), 32'h2ABCD);
        chk("R10", "pending clr", 32'(upd_pending), 0);

        // R10 R3 running: transfer waits for limit event
        wr(3'd3, 18'd0);
        wr(3'd2, 18'd9);
        wr(3'd1, 18'd4);
        idle(2);
        wr(3'd4, 18'd7);
        wr(3'd0, mk_cfg(3'd0, 2'd3, 0, 0, 0, 0, 0, 0, 1));
        wr(3'd1, 18'd7);
        chk("R10", "run pending", 32'(upd_pending), 1);
        chk("R10", "run cmp held", 32'(cmp_value), 4);
        idle(14);
        chk("R10", "run cmp moved", 32'(cmp_value), 7);
        chk("R10", "run pending clr", 32'(upd_pending), 0);
        chk("R3", "limit flag", 32'(lim_flag), 1);
        wr(3'd0, mk_cfg(3'd0, 2'd3, 0, 0, 0, 0, 0, 0, 0));

        // R9 capture through synchronizer
        wr(3'd4, 18'd7);
        wr(3'd0, mk_cfg(3'd3, 2'd3, 0, 1, 0, 0, 0, 0, 0));
        wr(3'd3, 18'h1234);
        cap_in = 1'b1;
        idle(4);
        chk("R9", "rise capture", 32'(cmp_value), 32'h1234);
        chk("R9", "capture flag", 32'(cc_flag), 1);
        wr(3'd3, 18'h0042);
        cap_in = 1'b0;
        idle(4);
        chk("R9", "fall ignored", 32'(cmp_value), 32'h1234);
        wr(3'd0, mk_cfg(3'd3, 2'd3, 0, 0, 1, 0, 0, 0, 0));
        cap_in = 1'b1;
        idle(4);
        chk("R9", "rise ignored", 32'(cmp_value), 32'h1234);
        wr(3'd3, 18'h0077);
        cap_in = 1'b0;
        idle(4);
        chk("R9", "fall capture", 32'(cmp_value), 32'h0077);
        wr(3'd0, mk_cfg(3'd3, 2'd3, 0, 1, 1, 0, 0, 0, 0));
        wr(3'd3, 18'h0099);
        cap_in = 1'b1;
        idle(4);
        chk("R9", "both edges", 32'(cmp_value), 32'h0099);

        // R13 interrupt gating
        wr(3'd0, mk_cfg(3'd3, 2'd3, 0, 0, 0, 0, 0, 0, 0));
        chk("R13", "irq masked", 32'(irq), 0);
        wr(3'd0, mk_cfg(3'd3, 2'd3, 0, 0, 0, 1, 0, 0, 0));
        chk("R13", "irq enabled", 32'(irq), 1);
        wr(3'd4, 18'd1);
        chk("R12", "cc cleared", 32'(cc_flag), 0);
        chk("R13", "irq after clear", 32'(irq), 0);

        // R12 clear collides with a new limit event
        wr(3'd3, 18'd0);
        wr(3'd2, 18'd0);
        wr(3'd0, mk_cfg(3'd0, 2'd3, 0, 0, 0, 0, 0, 1, 1));
        idle(2);
        chk("R13", "lim irq", 32'(irq), 1);
        wr(3'd4, 18'd4);
        chk("R12", "set wins", 32'(lim_flag), 1);
        wr(3'd0, mk_cfg(3'd0, 2'd3, 0, 0, 0, 0, 0, 1, 0));
        wr(3'd4, 18'd4);
        chk("R12", "clear when idle", 32'(lim_flag), 0);

        // R14 direct output level
        wr(3'd5, 18'd1);
        chk("R14", "out high", 32'(pwm_out), 1);
        wr(3'd5, 18'd0);
        chk("R14", "out low", 32'(pwm_out), 0);

        // R2 count load and hold while stopped
        wr(3'd3, 18'h0500);
        idle(5);
        chk("R2", "held", 32'(count), 32'h0500);

        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule